// File: doc/BRIEF.md
# Opcode Decoder with Legality Guard

This block takes one 16-bit instruction word at a time, splits it into its fields and screens it against a fixed legality table before any operand is fetched. The table holds, for every 5-bit operation number, the operand count the operation needs, the sizes it accepts and any fixed addressing mode. A legal word produces a one-cycle decode strobe together with the registered fields. For a branch, the strobe also carries a taken flag computed from the status flags presented with the word. An illegal word, or a divide-by-zero report from the execute stage, stops the block. Halt rises, an error code is latched and held until reset, and every later word is refused.

A controller presents a word with `op_valid`. The decoded fields, the strobe, the taken flag, the error code and halt all appear after the next rising clock edge. A halt instruction that passes the checks is decoded normally and then stops the block without an error.

The block is built as a three-state machine:
- ST_RUN accepts words.
- ST_STOP is entered from ST_RUN by a legal halt word.
- ST_FAULT is entered from ST_RUN by an illegal word or by a divide-by-zero report.

Both stop states are left only by reset. In ST_RUN, a word with no violation and no halt keeps the machine in ST_RUN.

Top module: `opdec_guard`

## Requirements
- R1: After reset, dec_valid, halt, br_taken and err_code are 0 and all field outputs are 0.
- R2: One edge after an accepted word, the fields appear as follows: op_name is bits 15:11, op_size is bits 10:9 (0 byte, 1 word, 2 long), two_ops is bit 8 (operand count minus one), mode1/reg1 are bits 7:5/bit 4 and mode2/reg2 are bits 3:1/bit 0.
- R3: imm always shows bits 7:4. fmt2 is 1 exactly for the immediate-form operations: 1, 3, 12, 13, 14, 15 and 25.
- R4: When bit 8 differs from the count the operation needs, err_code becomes 1. Operations 0, 2, 4, 5, 9, 10, 11, 16, 24, 26 and 27 need bit 8 = 1; all others need 0. For example, 0x0900 is rejected with 1.
- R5: When the size is not allowed, err_code becomes 2. Operations 18–23, 27 and 4 allow only word. Operations 26 and 5 allow only long. Operations 30 and 31 allow only byte. All others allow byte, word or long but not size 3. For example, 0x9060 is rejected with 2.
- R6: When a fixed mode is broken, err_code becomes 3. Operations 18–23 and 27 need mode1 = 3. Operation 27 also needs mode2 = 1. Operation 26 needs mode1 and mode2 each in {0, 1}. For example, 0x9200 is rejected with 3.
- R7: When several violations occur together, the code reported is 1 before 2 before 3.
- R8: For a legal branch, br_taken is set as follows, with flags {n,z,v,c}: operation 18 always; 19 if v; 20 if z; 21 if c; 22 if !(n^v); 23 if (n^v)|z. br_taken is 0 for every other word.
- R9: A legal word with operation 31 pulses dec_valid. From the same cycle on, halt is 1 with err_code 0, and later words are refused.
- R10: div_zero in ST_RUN sets err_code 4 and halt one edge later, even if a word is presented in the same cycle.
- R11: Once err_code is nonzero, it, halt and all field outputs hold until reset, and dec_valid stays 0.
- R12: A legal word gives dec_valid = 1 and err_code 0 for exactly the one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction word present |
| opcode | input | 16 | Instruction word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| div_zero | input | 1 | Execute stage reports a zero divisor |
| dec_valid | output | 1 | Legal word decoded (one-cycle pulse) |
| halt | output | 1 | Block stopped |
| err_code | output | 3 | 0 none, 1 count, 2 size, 3 mode, 4 divide by zero |
| op_name | output | 5 | Operation number |
| op_size | output | 2 | Size field |
| two_ops | output | 1 | Operand count minus one |
| mode1 | output | 3 | First operand mode |
| reg1 | output | 1 | First operand register |
| mode2 | output | 3 | Second operand mode |
| reg2 | output | 1 | Second operand register |
| imm | output | 4 | Immediate field |
| fmt2 | output | 1 | Immediate-form operation |
| br_taken | output | 1 | Branch condition true for a legal branch |

## Verification
Every result is due one rising edge after the edge that samples `op_valid` or `div_zero`. This covers the fields, dec_valid, br_taken, err_code and halt; halt follows the registered state, so it rises in that same cycle. The bench changes inputs on falling edges and samples outputs on the falling edge that follows the capturing edge, so each check reads the first cycle in which the result is due. For the pulse and hold rules, it samples again one cycle later to confirm that dec_valid has dropped or that a latched value has not moved.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
    localparam int OPW   = 16;
    localparam int NAMEW = 5;
    localparam int SIZEW = 2;
    localparam int MODEW = 3;
    localparam int IMMW  = 4;
    localparam int ERRW  = 3;

    typedef enum logic [ERRW-1:0] {
        ERR_NONE  = 3'd0,
        ERR_COUNT = 3'd1,
        ERR_SIZE  = 3'd2,
        ERR_MODE  = 3'd3,
        ERR_DIVZ  = 3'd4
    } err_e;

    typedef enum logic [1:0] {ST_RUN, ST_STOP, ST_FAULT} state_e;

    localparam logic [SIZEW-1:0] SZ_B = 2'd0;
    localparam logic [SIZEW-1:0] SZ_W = 2'd1;
    localparam logic [SIZEW-1:0] SZ_L = 2'd2;

    localparam logic [MODEW-1:0] MD_DREG = 3'd0;
    localparam logic [MODEW-1:0] MD_AREG = 3'd1;
    localparam logic [MODEW-1:0] MD_ABS  = 3'd3;

    localparam logic [NAMEW-1:0] OP_MULS  = 5'd4;
    localparam logic [NAMEW-1:0] OP_DIVS  = 5'd5;
    localparam logic [NAMEW-1:0] OP_BRA   = 5'd18;
    localparam logic [NAMEW-1:0] OP_BVS   = 5'd19;
    localparam logic [NAMEW-1:0] OP_BEQ   = 5'd20;
    localparam logic [NAMEW-1:0] OP_BCS   = 5'd21;
    localparam logic [NAMEW-1:0] OP_BGE   = 5'd22;
    localparam logic [NAMEW-1:0] OP_BLE   = 5'd23;
    localparam logic [NAMEW-1:0] OP_EXG   = 5'd26;
    localparam logic [NAMEW-1:0] OP_MOVEA = 5'd27;
    localparam logic [NAMEW-1:0] OP_DSR   = 5'd30;
    localparam logic [NAMEW-1:0] OP_HLT   = 5'd31;

    typedef struct packed {
        logic [NAMEW-1:0] name;
        logic [SIZEW-1:0] size;
        logic             two;
        logic [MODEW-1:0] m1;
        logic             r1;
        logic [MODEW-1:0] m2;
        logic             r2;
        logic [IMMW-1:0]  imm;
        logic             fmt2;
    } fields_t;
endpackage

// File: rtl/opdec_split.sv
module opdec_split
    import opdec_pkg::*;
(
    input  logic [OPW-1:0] word,
    output fields_t        fld
);
    always_comb begin
        fld.name = word[15:11];
        fld.size = word[10:9];
        fld.two  = word[8];
        fld.m1   = word[7:5];
        fld.r1   = word[4];
        fld.m2   = word[3:1];
        fld.r2   = word[0];
        fld.imm  = word[7:4];
        unique case (word[15:11])
            5'd1, 5'd3, 5'd12, 5'd13, 5'd14, 5'd15, 5'd25: fld.fmt2 = 1'b1;
            default:                                        fld.fmt2 = 1'b0;
        endcase
    end
endmodule

// File: rtl/opdec_rules.sv
module opdec_rules
    import opdec_pkg::*;
(
    input  logic [NAMEW-1:0] name,
    input  logic [SIZEW-1:0] size,
    input  logic             two,
    input  logic [MODEW-1:0] m1,
    input  logic [MODEW-1:0] m2,
    output err_e             verdict
);
    logic need_two;
    logic size_ok;
    logic mode_ok;

    always_comb begin
        unique case (name)
            5'd0, 5'd2, 5'd4, 5'd5, 5'd9, 5'd10, 5'd11,
            5'd16, 5'd24, 5'd26, 5'd27: need_two = 1'b1;
            default:                    need_two = 1'b0;
        endcase
    end

    always_comb begin
        unique case (name)
            OP_BRA, OP_BVS, OP_BEQ, OP_BCS, OP_BGE, OP_BLE,
            OP_MOVEA, OP_MULS:  size_ok = (size == SZ_W);
            OP_EXG, OP_DIVS:    size_ok = (size == SZ_L);
            OP_DSR, OP_HLT:     size_ok = (size == SZ_B);
            default:            size_ok = (size != 2'd3);
        endcase
    end

    always_comb begin
        unique case (name)
            OP_BRA, OP_BVS, OP_BEQ, OP_BCS, OP_BGE, OP_BLE:
                mode_ok = (m1 == MD_ABS);
            OP_MOVEA:
                mode_ok = (m1 == MD_ABS) && (m2 == MD_AREG);
            OP_EXG:
                mode_ok = ((m1 == MD_DREG) || (m1 == MD_AREG)) &&
                          ((m2 == MD_DREG) || (m2 == MD_AREG));
            default:
                mode_ok = 1'b1;
        endcase
    end

    always_comb begin
        if (two != need_two)  verdict = ERR_COUNT;
        else if (!size_ok)    verdict = ERR_SIZE;
        else if (!mode_ok)    verdict = ERR_MODE;
        else                  verdict = ERR_NONE;
    end
endmodule

// File: rtl/opdec_cond.sv
module opdec_cond
    import opdec_pkg::*;
(
    input  logic [NAMEW-1:0] name,
    input  logic             n,
    input  logic             z,
    input  logic             v,
    input  logic             c,
    output logic             take
);
    always_comb begin
        unique case (name)
            OP_BRA:  take = 1'b1;
            OP_BVS:  take = v;
            OP_BEQ:  take = z;
            OP_BCS:  take = c;
            OP_BGE:  take = ~(n ^ v);
            OP_BLE:  take = (n ^ v) | z;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/opdec_guard.sv
module opdec_guard
    import opdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPW-1:0]   opcode,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic             flag_v,
    input  logic             flag_c,
    input  logic             div_zero,
    output logic             dec_valid,
    output logic             halt,
    output logic [ERRW-1:0]  err_code,
    output logic [NAMEW-1:0] op_name,
    output logic [SIZEW-1:0] op_size,
    output logic             two_ops,
    output logic [MODEW-1:0] mode1,
    output logic             reg1,
    output logic [MODEW-1:0] mode2,
    output logic             reg2,
    output logic [IMMW-1:0]  imm,
    output logic             fmt2,
    output logic             br_taken
);
    state_e  st_q, st_d;
    fields_t f_c, f_q;
    err_e    rule_err, err_q;
    logic    take_c, valid_q, take_q;

    opdec_split u_split (.word(opcode), .fld(f_c));

    opdec_rules u_rules (
        .name(f_c.name), .size(f_c.size), .two(f_c.two),
        .m1(f_c.m1), .m2(f_c.m2), .verdict(rule_err)
    );

    opdec_cond u_cond (
        .name(f_c.name), .n(flag_n), .z(flag_z), .v(flag_v), .c(flag_c),
        .take(take_c)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (div_zero)
                    st_d = ST_FAULT;
                else if (op_valid) begin
                    if (rule_err != ERR_NONE)  st_d = ST_FAULT;
                    else if (f_c.name == OP_HLT) st_d = ST_STOP;
                end
            end
            ST_STOP:  st_d = ST_STOP;
            ST_FAULT: st_d = ST_FAULT;
            default:  st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q     <= '0;
            err_q   <= ERR_NONE;
            valid_q <= 1'b0;
            take_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            take_q  <= 1'b0;
            if (st_q == ST_RUN) begin
                if (div_zero) begin
                    err_q <= ERR_DIVZ;
                end else if (op_valid) begin
                    f_q     <= f_c;
                    err_q   <= rule_err;
                    valid_q <= (rule_err == ERR_NONE);
                    take_q  <= (rule_err == ERR_NONE) && take_c;
                end
            end
        end
    end

    assign halt      = (st_q != ST_RUN);
    assign dec_valid = valid_q;
    assign br_taken  = take_q;
    assign err_code  = err_q;
    assign op_name   = f_q.name;
    assign op_size   = f_q.size;
    assign two_ops   = f_q.two;
    assign mode1     = f_q.m1;
    assign reg1      = f_q.r1;
    assign mode2     = f_q.m2;
    assign reg2      = f_q.r2;
    assign imm       = f_q.imm;
    assign fmt2      = f_q.fmt2;
endmodule

// File: rtl/opdec_guard_chk.sv
module opdec_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic       dec_valid,
    input logic       halt,
    input logic [2:0] err_code,
    input logic [4:0] op_name,
    input logic       br_taken
);
    // R11
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |=> $stable(err_code) && $stable(op_name));

    // R11
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |-> !dec_valid);

    // R10
    err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |-> halt);

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R12
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(op_valid));

    // R8
    taken_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> dec_valid);
endmodule

bind opdec_guard opdec_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dec_valid(dec_valid),
    .halt(halt), .err_code(err_code), .op_name(op_name), .br_taken(br_taken)
);

// File: tb/sim_opdec_guard.sv
module sim_opdec_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic        div_zero = 1'b0;
    logic        dec_valid, halt, two_ops, reg1, reg2, fmt2, br_taken;
    logic [2:0]  err_code, mode1, mode2;
    logic [4:0]  op_name;
    logic [1:0]  op_size;
    logic [3:0]  imm;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    opdec_guard u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .div_zero(div_zero), .dec_valid(dec_valid), .halt(halt),
        .err_code(err_code), .op_name(op_name), .op_size(op_size),
        .two_ops(two_ops), .mode1(mode1), .reg1(reg1), .mode2(mode2),
        .reg2(reg2), .imm(imm), .fmt2(fmt2), .br_taken(br_taken)
    );

    // {opcode, flags nzvc, err, valid, taken, halt}
    localparam int NV = 28;
    localparam logic [25:0] VEC [NV] = '{
        {16'h0900, 4'b0000, 3'd1, 1'b0, 1'b0, 1'b1},  // R4 quick add, bit 8 set
        {16'h0401, 4'b0000, 3'd1, 1'b0, 1'b0, 1'b1},  // R4 add, bit 8 clear
        {16'hF100, 4'b0000, 3'd1, 1'b0, 1'b0, 1'b1},  // R4 status display with operand
        {16'h9060, 4'b0000, 3'd2, 1'b0, 1'b0, 1'b1},  // R5 byte branch
        {16'h0701, 4'b0000, 3'd2, 1'b0, 1'b0, 1'b1},  // R5 size 3
        {16'h2501, 4'b0000, 3'd2, 1'b0, 1'b0, 1'b1},  // R5 long multiply
        {16'hF200, 4'b0000, 3'd2, 1'b0, 1'b0, 1'b1},  // R5 word status display
        {16'h9200, 4'b0000, 3'd3, 1'b0, 1'b0, 1'b1},  // R6 branch via data reg
        {16'hD583, 4'b0000, 3'd3, 1'b0, 1'b0, 1'b1},  // R6 exchange indirect
        {16'hDB60, 4'b0000, 3'd3, 1'b0, 1'b0, 1'b1},  // R6 move-address to data reg
        {16'h9100, 4'b0000, 3'd1, 1'b0, 1'b0, 1'b1},  // R7 count over size and mode
        {16'h9000, 4'b0000, 3'd2, 1'b0, 1'b0, 1'b1},  // R7 size over mode
        {16'h9260, 4'b0000, 3'd0, 1'b1, 1'b1, 1'b0},  // R8 always
        {16'h9A60, 4'b0000, 3'd0, 1'b1, 1'b0, 1'b0},  // R8 v clear
        {16'h9A60, 4'b0010, 3'd0, 1'b1, 1'b1, 1'b0},  // R8 v set
        {16'hA260, 4'b0100, 3'd0, 1'b1, 1'b1, 1'b0},  // R8 z set
        {16'hAA60, 4'b1101, 3'd0, 1'b1, 1'b1, 1'b0},  // R8 c set
        {16'hAA60, 4'b1110, 3'd0, 1'b1, 1'b0, 1'b0},  // R8 c clear
        {16'hB260, 4'b1000, 3'd0, 1'b1, 1'b0, 1'b0},  // R8 ge n only
        {16'hB260, 4'b1010, 3'd0, 1'b1, 1'b1, 1'b0},  // R8 ge n and v
        {16'hBA60, 4'b0100, 3'd0, 1'b1, 1'b1, 1'b0},  // R8 le z
        {16'hBA60, 4'b0000, 3'd0, 1'b1, 1'b0, 1'b0},  // R8 le none
        {16'h0501, 4'b1111, 3'd0, 1'b1, 1'b0, 1'b0},  // R12 add long, never taken
        {16'h2301, 4'b0000, 3'd0, 1'b1, 1'b0, 1'b0},  // R12 word multiply
        {16'hD503, 4'b0000, 3'd0, 1'b1, 1'b0, 1'b0},  // R12 exchange regs
        {16'hDB62, 4'b0000, 3'd0, 1'b1, 1'b0, 1'b0},  // R12 move-address
        {16'hF000, 4'b0000, 3'd0, 1'b1, 1'b0, 1'b0},  // R12 byte status display
        {16'hF800, 4'b0000, 3'd0, 1'b1, 1'b0, 1'b1}   // R9 halt word
    };

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; div_zero = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [15:0] w, input logic [3:0] f);
        opcode = w;
        {flag_n, flag_z, flag_v, flag_c} = f;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 dec_valid", dec_valid, 0);
        check("R1 halt", halt, 0);
        check("R1 err_code", err_code, 0);
        check("R1 br_taken", br_taken, 0);
        check("R1 fields", {op_name, op_size, two_ops, mode1, reg1, mode2, reg2, imm, fmt2}, 0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            send(VEC[i][25:10], VEC[i][9:6]);
            check($sformatf("R4-7 vec%0d err", i), err_code, VEC[i][5:3]);
            check($sformatf("R12 vec%0d valid", i), dec_valid, VEC[i][2]);
            check($sformatf("R8 vec%0d taken", i), br_taken, VEC[i][1]);
            check($sformatf("R9 vec%0d halt", i), halt, VEC[i][0]);
        end

        // R2 field split, move with modes 5 and 2
        do_reset();
        send(16'hC5B5, 4'b0000);
        check("R2 op_name", op_name, 24);
        check("R2 op_size", op_size, 2);
        check("R2 two_ops", two_ops, 1);
        check("R2 mode1", mode1, 5);
        check("R2 reg1", reg1, 1);
        check("R2 mode2", mode2, 2);
        check("R2 reg2", reg2, 1);
        check("R2 fmt2", fmt2, 0);
        check("R2 valid", dec_valid, 1);

        // R3 immediate form, quick move
        send(16'hCCA1, 4'b0000);
        check("R3 imm", imm, 4'hA);
        check("R3 fmt2", fmt2, 1);
        check("R3 valid", dec_valid, 1);

        // R12 pulse length: drops after one cycle
        @(negedge clk);
        check("R12 pulse drop", dec_valid, 0);
        check("R12 no error", err_code, 0);

        // R10 divide by zero
        do_reset();
        div_zero = 1'b1;
        @(negedge clk);
        div_zero = 1'b0;
        check("R10 err", err_code, 4);
        check("R10 halt", halt, 1);

        // R10 together with a word
        do_reset();
        div_zero = 1'b1;
        send(16'h0501, 4'b0000);
        div_zero = 1'b0;
        check("R10 simul err", err_code, 4);
        check("R10 simul valid", dec_valid, 0);

        // R11 hold after error
        do_reset();
        send(16'h0900, 4'b0000);
        send(16'h0501, 4'b0000);
        check("R11 err held", err_code, 1);
        check("R11 no strobe", dec_valid, 0);
        check("R11 fields held", op_name, 1);
        div_zero = 1'b1;
        @(negedge clk);
        div_zero = 1'b0;
        check("R11 err after divz", err_code, 1);
        check("R11 halt", halt, 1);

        // R9 after halt, later word refused
        do_reset();
        send(16'hF800, 4'b0000);
        send(16'h9260, 4'b0000);
        check("R9 refused", dec_valid, 0);
        check("R9 halt held", halt, 1);
        check("R9 no error", err_code, 0);
        check("R9 fields kept", op_name, 31);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule